// File: doc/BRIEF.md
# Clock and Reset Control Register Block

This block is the software-visible register file for an SoC's clock and reset controls: one oscillator configuration word, three PLLs (core, memory and network), each with a divider/status word and, for two of them, an enable word, plus the core clock select, a peripheral reset mask and a clock mux status word. It sits on a plain 32-bit register bus with a request strobe, write enable, byte address, access size, write data, read data and an error flag.

The block stands in for hardware that is always ready. Whatever software writes, the oscillator reports ready and every PLL reports lock and internal feedback, so boot code that polls these bits never stalls. The core clock select and the peripheral reset mask leave the block as dedicated outputs. Any access outside the register map, any access that is not a full aligned word, is refused with the error flag and changes nothing.

Top module: `clkrst_csr`

## Requirements
- R1: Nine word registers answer at byte offsets 0x00 (oscillator), 0x04 (core PLL divider), 0x0C (memory PLL divider), 0x10 (memory PLL enable), 0x1C (network PLL divider), 0x20 (network PLL enable), 0x24 (core clock select), 0x28 (peripheral reset mask), 0x2C (mux status); a read of each offset returns that register and no other.
- R2: After reset the oscillator word is 0xC000_0000 (bit 30 enable, bit 31 ready), each PLL divider word is 0x8201_87C1 (bit 0 ref divider, bits 10:6 feedback divider, bits 16:15 output divider, bit 25 internal feedback, bit 31 lock), the core clock select is 0x1 and every other register is 0.
- R3: A write to the oscillator word stores the write data with bit 31 set to 1.
- R4: A write to any PLL divider word stores the write data with bits 25 and 31 set to 1.
- R5: Writes to both PLL enable words (bit 24 is the clock enable), the core clock select, the peripheral reset mask and the mux status store all 32 bits unchanged.
- R6: A read or write at an offset of the 4 KiB window not listed in R1 raises the error flag, returns read data 0 and changes no register.
- R7: The size input encodes 0 = byte, 1 = halfword, 2 = word; an access with size other than 2, or with address bits 1:0 not zero, raises the error flag, returns read data 0 and changes no register.
- R8: Read data and error flag are registered: they answer in the cycle after the request, and are 0 in any cycle that does not follow a request; a write returns read data 0.
- R9: The core clock select and peripheral reset mask drive output ports continuously and change on the clock edge that accepts the write.
- R10: Reset is synchronous and active low and returns every register and both response outputs to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one per asserted cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| err | output | 1 | Error flag, one cycle after the request |
| core_clk_sel | output | 32 | Core clock select register |
| periph_rst | output | 32 | Peripheral reset mask register |

## Verification
Each access is a single-cycle request; register contents, the core clock select and the reset mask change on the edge that accepts it, and read data and the error flag appear on that same edge, so all of them are due one cycle after the request. The bench drives requests on the falling edge and samples everything on the next falling edge, half a cycle after that update, and then samples one idle cycle later to see both response outputs back at 0. Refused accesses are checked by reading the neighbouring registers back and by watching the two outputs.

// File: rtl/clkrst_csr_pkg.sv
// Package: register map, reset values and forced-bit masks for the
// clock and reset control register block.
// Assumes a 32-bit data path and word-aligned register offsets.
package clkrst_csr_pkg;

    localparam int DATA_W  = 32;
    localparam int NREG    = 9;

    // Access size codes on the size input
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Register slot indices
    localparam int IX_OSC     = 0;
    localparam int IX_CPLL0   = 1;
    localparam int IX_MPLL0   = 2;
    localparam int IX_MPLL1   = 3;
    localparam int IX_NPLL0   = 4;
    localparam int IX_NPLL1   = 5;
    localparam int IX_CLKSEL  = 6;
    localparam int IX_PRST    = 7;
    localparam int IX_MUXSTAT = 8;

    localparam logic [DATA_W-1:0] OSC_RDY   = 32'h8000_0000;
    localparam logic [DATA_W-1:0] OSC_EN    = 32'h4000_0000;
    localparam logic [DATA_W-1:0] PLL_LOCK  = 32'h8000_0000;
    localparam logic [DATA_W-1:0] PLL_FBINT = 32'h0200_0000;
    localparam logic [DATA_W-1:0] PLL_DIVS  = 32'h0001_87C1;

    // Byte offset of a register slot
    function automatic int reg_offset(input int ix);
        case (ix)
            IX_OSC:    return 'h00;
            IX_CPLL0:  return 'h04;
            IX_MPLL0:  return 'h0C;
            IX_MPLL1:  return 'h10;
            IX_NPLL0:  return 'h1C;
            IX_NPLL1:  return 'h20;
            IX_CLKSEL: return 'h24;
            IX_PRST:   return 'h28;
            default:   return 'h2C;
        endcase
    endfunction

    // True for the three PLL divider slots
    function automatic bit is_pll_div(input int ix);
        return (ix == IX_CPLL0) || (ix == IX_MPLL0) || (ix == IX_NPLL0);
    endfunction

    // Bits forced to 1 on every write
    function automatic logic [DATA_W-1:0] reg_force(input int ix);
        if (ix == IX_OSC)     return OSC_RDY;
        if (is_pll_div(ix))   return PLL_LOCK | PLL_FBINT;
        return '0;
    endfunction

    // Reset value of a slot
    function automatic logic [DATA_W-1:0] reg_reset(input int ix);
        if (ix == IX_OSC)     return OSC_RDY | OSC_EN;
        if (is_pll_div(ix))   return PLL_LOCK | PLL_FBINT | PLL_DIVS;
        if (ix == IX_CLKSEL)  return 32'h0000_0001;
        return '0;
    endfunction

endpackage

// File: rtl/clkrst_csr_decode.sv
// Address decoder: turns one bus request into per-register write
// strobes, a read-select vector and a refusal flag.
// Assumes the address covers exactly the block's window.
module clkrst_csr_decode
    import clkrst_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [NREG-1:0]   sel,
    output logic [NREG-1:0]   wr_stb,
    output logic              rd_go,
    output logic              bad
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [NREG-1:0] match;
    logic            legal;

    // Compare the word index with each register offset
    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign match[g] = (addr[ADDR_W-1:2] == WIDX_W'(reg_offset(g) >> 2));
    end

    // Full aligned words only
    assign legal = (size == SZ_WORD) && (addr[1:0] == 2'b00);

    // Form selects, strobes and the refusal flag
    always_comb begin
        sel    = legal ? match : '0;
        bad    = req && !(legal && (|match));
        wr_stb = (req && we) ? sel : '0;
        rd_go  = req && !we && !bad;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R1

    AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (wr_stb == '0) && !rd_go); // R6

endmodule

// File: rtl/clkrst_csr_reg.sv
// One 32-bit control word with a reset value and a mask of bits that
// every write forces to 1.
// Assumes the strobe is already qualified by a legal decoded access.
module clkrst_csr_reg #(
    parameter int               W         = 32,
    parameter logic [W-1:0]     RST_VAL   = '0,
    parameter logic [W-1:0]     FORCE_SET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold the word; forced bits follow every write
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (wr)  q <= wdata | FORCE_SET;
    end

    AST_FORCED_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr) |-> ((q & FORCE_SET) == FORCE_SET)); // R4

    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q)); // R6

endmodule

// File: rtl/clkrst_csr_rdmux.sv
// Read return path: selects the addressed word and registers it with
// the error flag so both answer one cycle after the request.
// Assumes sel is one-hot or zero.
module clkrst_csr_rdmux
    import clkrst_csr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [NREG-1:0][DATA_W-1:0] words,
    input  logic [NREG-1:0]             sel,
    input  logic                        rd_go,
    input  logic                        bad,
    output logic [DATA_W-1:0]           rdata,
    output logic                        err
);
    logic [DATA_W-1:0] pick;

    // AND-OR select of the addressed word
    always_comb begin
        pick = '0;
        for (int i = 0; i < NREG; i++)
            pick |= words[i] & {DATA_W{sel[i]}};
    end

    // Register the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_go ? pick : '0;
            err   <= bad;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0)); // R7

    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !err && (rdata == '0)); // R8

endmodule

// File: rtl/clkrst_csr.sv
// Clock and reset control register block: nine control words behind a
// single-cycle register bus, with always-ready status bits and the
// core clock select and peripheral reset mask brought out as ports.
// Assumes one request per cycle and no back-pressure.
module clkrst_csr
    import clkrst_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic [31:0]       core_clk_sel,
    output logic [31:0]       periph_rst
);
    logic [NREG-1:0]             sel;
    logic [NREG-1:0]             wr_stb;
    logic                        rd_go;
    logic                        bad;
    logic [NREG-1:0][DATA_W-1:0] words;

    clkrst_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .we     (we),
        .addr   (addr),
        .size   (size),
        .sel    (sel),
        .wr_stb (wr_stb),
        .rd_go  (rd_go),
        .bad    (bad)
    );

    // One storage slot per mapped register
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        clkrst_csr_reg #(
            .W         (DATA_W),
            .RST_VAL   (reg_reset(g)),
            .FORCE_SET (reg_force(g))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_stb[g]),
            .wdata (wdata),
            .q     (words[g])
        );
    end

    clkrst_csr_rdmux u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .words (words),
        .sel   (sel),
        .rd_go (rd_go),
        .bad   (bad),
        .rdata (rdata),
        .err   (err)
    );

    // Export the two control words
    assign core_clk_sel = words[IX_CLKSEL];
    assign periph_rst   = words[IX_PRST];

    AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bad) |=> $stable(words)); // R6

    AST_OSC_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        words[IX_OSC][31]); // R3

    AST_PLL_ALWAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        words[IX_CPLL0][31] && words[IX_MPLL0][31] && words[IX_NPLL0][31]); // R4

endmodule

// File: tb/clkrst_csr_test.sv
`timescale 1ns/1ps
module clkrst_csr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [31:0] core_clk_sel;
    logic [31:0] periph_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkrst_csr uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .we           (we),
        .addr         (addr),
        .size         (size),
        .wdata        (wdata),
        .rdata        (rdata),
        .err          (err),
        .core_clk_sel (core_clk_sel),
        .periph_rst   (periph_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One access; response sampled one cycle later on the falling edge
    task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; size = sz; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata; er = err;
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input logic exp_err);
        logic [31:0] rd; logic er;
        access(1'b1, a, sz, d, rd, er);
        check({tag, " write err"}, {31'd0, er}, {31'd0, exp_err});
        check({tag, " write rdata"}, rd, 32'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] rd; logic er;
        access(1'b0, a, sz, 32'h0, rd, er);
        check({tag, " read err"}, {31'd0, er}, {31'd0, exp_err});
        check({tag, " read data"}, rd, exp_err ? 32'h0 : exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2 R10 R9: reset values of all words and both outputs
    task automatic t_reset_values(input string tag);
        check({tag, " R9 core_clk_sel"}, core_clk_sel, 32'h1);
        check({tag, " R9 periph_rst"}, periph_rst, 32'h0);
        check({tag, " R10 err"}, {31'd0, err}, 32'h0);
        check({tag, " R10 rdata"}, rdata, 32'h0);
        rd_chk({tag, " R2 osc"},   12'h000, 2'd2, 32'hC000_0000, 1'b0);
        rd_chk({tag, " R2 cpll"},  12'h004, 2'd2, 32'h8201_87C1, 1'b0);
        rd_chk({tag, " R2 mpll"},  12'h00C, 2'd2, 32'h8201_87C1, 1'b0);
        rd_chk({tag, " R2 mpll1"}, 12'h010, 2'd2, 32'h0, 1'b0);
        rd_chk({tag, " R2 npll"},  12'h01C, 2'd2, 32'h8201_87C1, 1'b0);
        rd_chk({tag, " R2 npll1"}, 12'h020, 2'd2, 32'h0, 1'b0);
        rd_chk({tag, " R2 clksel"},12'h024, 2'd2, 32'h1, 1'b0);
        rd_chk({tag, " R2 prst"},  12'h028, 2'd2, 32'h0, 1'b0);
        rd_chk({tag, " R2 mux"},   12'h02C, 2'd2, 32'h0, 1'b0);
    endtask

    // R3: oscillator ready forced on write
    task automatic t_osc();
        wr("R3 osc zero", 12'h000, 32'h0000_0000, 2'd2, 1'b0);
        rd_chk("R3 osc zero", 12'h000, 2'd2, 32'h8000_0000, 1'b0);
        wr("R3 osc pat", 12'h000, 32'h4000_1234, 2'd2, 1'b0);
        rd_chk("R3 osc pat", 12'h000, 2'd2, 32'hC000_1234, 1'b0);
    endtask

    // R4: PLL lock and internal feedback forced on write
    task automatic t_pll();
        wr("R4 cpll", 12'h004, 32'h0000_0000, 2'd2, 1'b0);
        wr("R4 mpll", 12'h00C, 32'h0000_0003, 2'd2, 1'b0);
        wr("R4 npll", 12'h01C, 32'h7DFF_FFFF, 2'd2, 1'b0);
        rd_chk("R4 cpll", 12'h004, 2'd2, 32'h8200_0000, 1'b0);
        rd_chk("R4 mpll", 12'h00C, 2'd2, 32'h8200_0003, 1'b0);
        rd_chk("R4 npll", 12'h01C, 2'd2, 32'hFFFF_FFFF, 1'b0);
    endtask

    // R5 R1 R9: plain words store all bits, each offset distinct
    task automatic t_plain();
        wr("R5 mpll1", 12'h010, 32'h0100_0000, 2'd2, 1'b0);
        wr("R5 npll1", 12'h020, 32'hA5A5_5A5A, 2'd2, 1'b0);
        wr("R9 clksel", 12'h024, 32'h0000_0000, 2'd2, 1'b0);
        check("R9 core_clk_sel after write", core_clk_sel, 32'h0);
        wr("R9 prst", 12'h028, 32'hDEAD_BEEF, 2'd2, 1'b0);
        check("R9 periph_rst after write", periph_rst, 32'hDEAD_BEEF);
        wr("R5 mux", 12'h02C, 32'h1234_5678, 2'd2, 1'b0);
        rd_chk("R1 mpll1", 12'h010, 2'd2, 32'h0100_0000, 1'b0);
        rd_chk("R1 npll1", 12'h020, 2'd2, 32'hA5A5_5A5A, 1'b0);
        rd_chk("R1 clksel", 12'h024, 2'd2, 32'h0, 1'b0);
        rd_chk("R1 prst", 12'h028, 2'd2, 32'hDEAD_BEEF, 1'b0);
        rd_chk("R1 mux", 12'h02C, 2'd2, 32'h1234_5678, 1'b0);
    endtask

    // R6: unmapped offsets refused, nothing changes
    task automatic t_unmapped();
        wr("R6 hole 08", 12'h008, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wr("R6 hole 14", 12'h014, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wr("R6 hole 18", 12'h018, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wr("R6 past 30", 12'h030, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wr("R6 top FFC", 12'hFFC, 32'hFFFF_FFFF, 2'd2, 1'b1);
        wr("R6 alias 424", 12'h424, 32'hFFFF_FFFF, 2'd2, 1'b1);
        check("R6 core_clk_sel kept", core_clk_sel, 32'h0);
        check("R6 periph_rst kept", periph_rst, 32'hDEAD_BEEF);
        rd_chk("R6 read hole", 12'h018, 2'd2, 32'h0, 1'b1);
        rd_chk("R6 cpll kept", 12'h004, 2'd2, 32'h8200_0000, 1'b0);
        rd_chk("R6 mpll kept", 12'h00C, 2'd2, 32'h8200_0003, 1'b0);
        rd_chk("R6 mpll1 kept", 12'h010, 2'd2, 32'h0100_0000, 1'b0);
        rd_chk("R6 npll kept", 12'h01C, 2'd2, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R6 mux kept", 12'h02C, 2'd2, 32'h1234_5678, 1'b0);
    endtask

    // R7: narrow or misaligned accesses refused
    task automatic t_badsize();
        wr("R7 byte write", 12'h024, 32'h0000_00FF, 2'd0, 1'b1);
        wr("R7 half write", 12'h028, 32'h0000_0000, 2'd1, 1'b1);
        wr("R7 size3 write", 12'h028, 32'h0000_0000, 2'd3, 1'b1);
        wr("R7 misaligned", 12'h026, 32'h0000_0007, 2'd2, 1'b1);
        wr("R7 misaligned pll", 12'h005, 32'h0000_0000, 2'd2, 1'b1);
        check("R7 core_clk_sel kept", core_clk_sel, 32'h0);
        check("R7 periph_rst kept", periph_rst, 32'hDEAD_BEEF);
        rd_chk("R7 half read", 12'h000, 2'd1, 32'h0, 1'b1);
        rd_chk("R7 misaligned read", 12'h002, 2'd2, 32'h0, 1'b1);
        rd_chk("R7 cpll kept", 12'h004, 2'd2, 32'h8200_0000, 1'b0);
    endtask

    // R8: response lasts exactly one cycle
    task automatic t_timing();
        logic [31:0] rd; logic er;
        access(1'b0, 12'h028, 2'd2, 32'h0, rd, er);
        check("R8 read due next cycle", rd, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R8 rdata idle", rdata, 32'h0);
        access(1'b0, 12'h040, 2'd2, 32'h0, rd, er);
        check("R8 err due next cycle", {31'd0, er}, 32'h1);
        @(negedge clk);
        check("R8 err idle", {31'd0, err}, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_values("R10 first");
        t_osc();
        t_pll();
        t_plain();
        t_unmapped();
        t_badsize();
        t_timing();
        do_reset();
        t_reset_values("R10 second");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule